// File: doc/BRIEF.md
# Incrementer-Based Carry Select Adder

This block adds two unsigned operands and a carry-in, and returns their sum and carry-out through a single output register. The operand width is a parameter and must be a multiple of four. The datapath splits each operand into 4-bit slices. The least significant slice is a plain ripple adder that takes the external carry-in. Every slice above it runs one ripple adder with its carry-in assumed to be zero. It then forms the carry-in-one result by adding one to that partial sum, so no second adder is needed. A multiplexer steered by the carry from the slice below chooses which of the two candidates goes to the output.

The combinational path can be placed wherever a short carry path matters, such as the final addition after a multiplier's reduction tree. The output register is there so that the block fits a synchronous datapath. A synchronous, active-high reset clears that register.

Top module: `inc_csel_adder`

## Requirements
- R1: The width parameter `WIDTH` must be a positive multiple of 4. Any other value stops elaboration with an error.
- R2: On each rising clock edge without reset, `{cout_o, sum_o}` takes the value `a_i + b_i + cin_i` of the operands present at that edge, computed as an unsigned addition that is `WIDTH+1` bits wide. The result is visible one cycle after the inputs are applied.
- R3: While `rst` is high at a rising edge, `sum_o` and `cout_o` are cleared to zero.
- R4: The least significant 4-bit slice adds its operand bits with `cin_i` directly, so `cin_i` changes bit 0 of the sum.
- R5: In every higher slice, the carry-in-one candidate is the 4-bit carry-in-zero sum plus one, modulo 16. Its carry equals the carry-in-zero carry ORed with the AND of all four carry-in-zero sum bits.
- R6: Each higher slice outputs its carry-in-one candidate when the selected carry of the slice below is 1, and its carry-in-zero candidate when that carry is 0.
- R7: `cout_o` is the selected carry of the most significant slice.
- R8: A carry propagates through every slice. All-ones `a_i` with zero `b_i` and `cin_i = 1` gives a sum of zero and a carry-out of 1.
- R9: The same RTL gives correct sums at `WIDTH` values of 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The assertions check the arithmetic and reset properties on every cycle:
- The registered output equals the full-width sum of the previous cycle's inputs.
- The outputs are zero on the first cycle after reset.
- In every slice, the incremented candidate is exactly one more than the carry-in-zero result.
- A selected carry never falls below the carry-in-zero carry.

Other behaviour is shown only by the bench's scenarios:
- The exhaustive nibble sweep with each carry-in value is repeated into every slice.
- Full-length ripple chains through all-ones operands.
- Random vectors run on the 16-, 32- and 64-bit builds side by side.
- A reset is applied in the middle of traffic.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int SEG_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef struct packed {
    seg_t sum;
    logic carry;
  } seg_res_t;
endpackage

// File: rtl/csa_rca.sv
module csa_rca
  import csa_pkg::*;
(
  input  seg_t a,
  input  seg_t b,
  input  logic ci,
  output seg_res_t res
);
  logic [SEG_W:0] chain;
  seg_t           s;

  assign chain[0] = ci;
  for (genvar i = 0; i < SEG_W; i++) begin : g_fa
    assign s[i]       = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign res.sum   = s;
  assign res.carry = chain[SEG_W];
endmodule

// File: rtl/csa_inc.sv
module csa_inc
  import csa_pkg::*;
(
  input  seg_res_t zero_res,
  output seg_res_t one_res
);
  logic [SEG_W:0] hc;
  seg_t           s;

  assign hc[0] = 1'b1;
  for (genvar i = 0; i < SEG_W; i++) begin : g_ha
    assign s[i]    = zero_res.sum[i] ^ hc[i];
    assign hc[i+1] = zero_res.sum[i] & hc[i];
  end

  assign one_res.sum   = s;
  assign one_res.carry = zero_res.carry | hc[SEG_W];

  always_comb begin
    AST_INC_CAND: assert ({one_res.carry, one_res.sum} ==
                          ({zero_res.carry, zero_res.sum} + 5'd1)); // R5
  end
endmodule

// File: rtl/csa_sel.sv
module csa_sel
  import csa_pkg::*;
(
  input  logic     pick_one,
  input  seg_res_t zero_res,
  input  seg_res_t one_res,
  output seg_res_t out_res
);
  always_comb begin
    if (pick_one) out_res = one_res;
    else          out_res = zero_res;
  end
endmodule

// File: rtl/inc_csel_adder.sv
module inc_csel_adder
  import csa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NSEG = WIDTH / SEG_W;

  if ((WIDTH % SEG_W) != 0 || WIDTH < SEG_W) begin : g_bad_width
    $error("inc_csel_adder: WIDTH must be a positive multiple of 4"); // R1
  end

  logic [NSEG:0]    sel_c;
  logic [WIDTH-1:0] sum_c;

  assign sel_c[0] = cin_i;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    seg_res_t zr;
    seg_res_t fin;
    if (k == 0) begin : g_low
      // R4: lowest slice takes the true carry-in, no selection stage
      csa_rca u_rca (
        .a  (a_i[k*SEG_W +: SEG_W]),
        .b  (b_i[k*SEG_W +: SEG_W]),
        .ci (sel_c[0]),
        .res(zr)
      );
      assign fin = zr;
    end else begin : g_high
      seg_res_t orr;
      csa_rca u_rca (
        .a  (a_i[k*SEG_W +: SEG_W]),
        .b  (b_i[k*SEG_W +: SEG_W]),
        .ci (1'b0),
        .res(zr)
      );
      csa_inc u_inc (
        .zero_res(zr),
        .one_res (orr)
      );
      csa_sel u_sel (
        .pick_one(sel_c[k]),
        .zero_res(zr),
        .one_res (orr),
        .out_res (fin)
      );
      always_comb begin
        AST_CARRY_MONO: assert (!zr.carry || fin.carry); // R6
      end
    end
    assign sum_c[k*SEG_W +: SEG_W] = fin.sum;
    assign sel_c[k+1]              = fin.carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= sel_c[NSEG]; // R7
    end
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_o, sum_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + (WIDTH+1)'($past(cin_i))))); // R2

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_o == '0 && !cout_o)); // R3
endmodule

// File: tb/inc_csel_adder_test.sv
module inc_csel_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [63:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] s16; logic c16;
  logic [31:0] s32; logic c32;
  logic [63:0] s64; logic c64;

  inc_csel_adder #(.WIDTH(32)) uut (
    .clk(clk), .rst(rst), .a_i(a[31:0]), .b_i(b[31:0]), .cin_i(cin),
    .sum_o(s32), .cout_o(c32));
  inc_csel_adder #(.WIDTH(16)) uut16 (
    .clk(clk), .rst(rst), .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin),
    .sum_o(s16), .cout_o(c16));
  inc_csel_adder #(.WIDTH(64)) uut64 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(s64), .cout_o(c64));

  typedef struct {
    logic [16:0] e16;
    logic [32:0] e32;
    logic [64:0] e64;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] av, input logic [63:0] bv, input logic cv, input string tag);
    item_t it;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    it.e16 = {1'b0, av[15:0]} + {1'b0, bv[15:0]} + 17'(cv);
    it.e32 = {1'b0, av[31:0]} + {1'b0, bv[31:0]} + 33'(cv);
    it.e64 = {1'b0, av} + {1'b0, bv} + 65'(cv);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops one expected item per cycle after the output register
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({c16, s16} == it.e16, {it.tag, " R9 w16"}, 65'({c16, s16}), 65'(it.e16));
      chk({c32, s32} == it.e32, {it.tag, " R2 w32"}, 65'({c32, s32}), 65'(it.e32));
      chk({c64, s64} == it.e64, {it.tag, " R9 w64"}, {c64, s64}, it.e64);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(s32 == 0 && !c32 && s16 == 0 && !c16 && s64 == 0 && !c64, "R3 reset state",
        65'({c32, s32}), 65'd0);
    rst = 1'b0;

    // R5 R6 R4: exhaustive nibble pair and carry-in, repeated in every slice
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          drive({16{x[3:0]}}, {16{y[3:0]}}, c[0], "R5 R6 nibble sweep");

    // R4: carry-in alone changes bit 0
    drive(64'd0, 64'd0, 1'b1, "R4 cin only");
    drive(64'd0, 64'd0, 1'b0, "R4 cin zero");

    // R8 R7: full ripple through all ones
    drive('1, 64'd0, 1'b1, "R8 all ones plus cin");
    drive('1, 64'd1, 1'b0, "R8 all ones plus one");
    drive('1, '1, 1'b1, "R7 max operands");
    drive(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0, "R7 top carry only");
    drive(64'h0FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R6 long select chain");

    // R9: random vectors at all widths
    for (int i = 0; i < 2000; i++)
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R9 random");

    repeat (3) @(posedge clk);

    // R3: reset in the middle of traffic
    @(negedge clk);
    a = '1; b = '1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk(s32 == 0 && !c32 && s64 == 0 && !c64, "R3 mid-run reset",
        {c64, s64}, 65'd0);
    rst = 1'b0;
    drive(64'd5, 64'd7, 1'b1, "R2 after reset");
    repeat (3) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule